// File: doc/BRIEF.md
# Mirror Block Operation Decoder

This block turns one block request per row cycle into the control masks for a 16-block mirror array. When a row load begins, the controller samples a 2-bit operation mode, a 4-bit block address and a grouping select. One clock later it outputs a single-cycle pulse on one of three 16-bit masks: memory clear, reset pulse or park. One bit of each mask stands for one block.

Around the decode, the block enforces the row-cycle rules that protect the array. A variant input selects a 15-block array. In that variant block 15 does not exist, and every clear must be followed by two no-op row cycles. A clear is refused while a different block is being written. A change of the grouping select applies only one row cycle after it is first sampled.

A request that breaks a rule produces all-zero masks. It also raises a one-cycle violation pulse and sets an error flag that stays set until reset.

Top module: `mirror_blkop_decoder`

## Requirements
- R1: A request is sampled only on a clock edge where `row_start` is high. Its masks and violation pulse appear in the next cycle and last exactly one clock. In every other cycle, and after reset, all masks, `viol_pulse` and `err_flag` are zero.
- R2: Mode 00 is a no-op. All three masks stay zero whatever the address, and the request is never a violation on its own.
- R3: Mode 01 sets exactly bit `blk_addr` of `clear_mask`. The grouping select has no effect.
- R4: Mode 10 sets exactly bit `blk_addr` of `reset_mask`. The grouping select has no effect.
- R5: In mode 11 with address bit 3 at 0 and an applied grouping select of 0, `reset_mask` has bits 2a and 2a+1 set, where a is address bits 2..0.
- R6: In mode 11 with address bit 3 at 0 and an applied grouping select of 1, `reset_mask` has bits 4b to 4b+3 set, where b is address bits 2..1.
- R7: In mode 11, address 10xx sets every existing block in `reset_mask`, and address 11xx sets every existing block in `park_mask`. The grouping select has no effect on either.
- R8: With `short_array` high, bit 15 of every mask stays zero. A clear or reset aimed only at block 15 produces all-zero masks and no violation.
- R9: With `short_array` high, a clear that is carried out starts a holdoff of two row cycles. During the holdoff, any mode other than 00 is a violation. With `short_array` low, no holdoff exists.
- R10: A clear with `wr_active` high and `wr_blk` different from `blk_addr` is a violation. A clear of the block being written, a clear while no write is active, and a reset while a write is active are all accepted.
- R11: A violating request gives all-zero masks, pulses `viol_pulse` for one clock and sets `err_flag`. The flag stays set until reset.
- R12: The grouping select sampled at one row start governs the decode of the next row start. The first row after reset uses 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_start | input | 1 | High for one clock at the start of each row load |
| op_mode | input | 2 | Operation mode: 00 no-op, 01 clear, 10 single reset, 11 group |
| blk_addr | input | 4 | Block address or group code |
| grp_sel | input | 1 | Grouping select: 0 pairs, 1 quads |
| short_array | input | 1 | High selects the 15-block variant |
| wr_active | input | 1 | A block is being written in this row cycle |
| wr_blk | input | 4 | Block being written |
| clear_mask | output | 16 | One-clock pulse: blocks whose memory is cleared |
| reset_mask | output | 16 | One-clock pulse: blocks that receive a reset pulse |
| park_mask | output | 16 | One-clock pulse: blocks that are parked |
| viol_pulse | output | 1 | One-clock pulse: the sampled request broke a rule |
| err_flag | output | 1 | Set by a violation, cleared only by reset |

## Verification
Two internal states can go wrong without showing at once: the holdoff counter and the pending grouping select. A holdoff counter that is stuck or loaded wrongly shows up on the first or second row after a clear. The bench checks this by placing a non-no-op request at each of those rows and one just after the holdoff ends. A wrong pending grouping select first shows on the row after the change, as a pair mask where a quad was expected or the reverse. The bench therefore changes the select and checks the very next row and the one after it. A lost reset of the sticky flag or the output registers is visible in the first check after each reset.

// File: rtl/mbo_pkg.sv
package mbo_pkg;

    localparam int NUM_BLK   = 16;
    localparam int ADDR_W    = 4;
    localparam int HOLD_ROWS = 2;

    typedef enum logic [1:0] {
        OP_NOP = 2'b00,
        OP_CLR = 2'b01,
        OP_RST = 2'b10,
        OP_GRP = 2'b11
    } op_e;

    typedef logic [NUM_BLK-1:0] blk_mask_t;

    typedef struct packed {
        blk_mask_t clr;
        blk_mask_t rst;
        blk_mask_t park;
    } blk_masks_t;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
        logic              wr_act;
        logic [ADDR_W-1:0] wr_blk;
    } row_req_t;

    // Expand one request into raw masks over all 16 blocks.
    function automatic blk_masks_t expand_req(op_e op, logic [ADDR_W-1:0] addr, logic quad);
        blk_masks_t m;
        m = '0;
        case (op)
            OP_CLR: m.clr = blk_mask_t'(1) << addr;
            OP_RST: m.rst = blk_mask_t'(1) << addr;
            OP_GRP: begin
                if (!addr[3]) begin
                    if (quad)
                        m.rst = blk_mask_t'(4'hF) << {addr[2:1], 2'b00};
                    else
                        m.rst = blk_mask_t'(2'b11) << {addr[2:0], 1'b0};
                end else if (!addr[2]) begin
                    m.rst = '1;
                end else begin
                    m.park = '1;
                end
            end
            default: m = '0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/mbo_grp_stage.sv
module mbo_grp_stage (
    input  logic clk,
    input  logic rst,
    input  logic row_start,
    input  logic grp_in,
    output logic grp_now
);
    // Holds the select sampled at the previous row start; the decode of the
    // current row uses this value, so a change lands one row later.
    logic grp_q;

    always_ff @(posedge clk) begin
        if (rst)
            grp_q <= 1'b0;
        else if (row_start)
            grp_q <= grp_in;
    end

    assign grp_now = grp_q;

    AST_GRP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !row_start |=> $stable(grp_now)); // R12

endmodule

// File: rtl/mbo_op_decode.sv
module mbo_op_decode
    import mbo_pkg::*;
#(
    parameter int BLOCKS = NUM_BLK
) (
    input  row_req_t   req,
    input  logic       quad,
    input  logic       short_array,
    output blk_masks_t masks
);
    localparam int LAST_BLK = BLOCKS - 1;

    blk_masks_t raw;
    blk_mask_t  present;

    assign raw = expand_req(req.op, req.addr, quad);

    generate
        for (genvar i = 0; i < BLOCKS; i++) begin : g_present
            if (i == LAST_BLK) begin : g_last
                assign present[i] = !short_array;
            end else begin : g_rest
                assign present[i] = 1'b1;
            end
        end
    endgenerate

    always_comb begin
        masks.clr  = raw.clr  & present;
        masks.rst  = raw.rst  & present;
        masks.park = raw.park & present;
    end

endmodule

// File: rtl/mbo_rule_check.sv
module mbo_rule_check
    import mbo_pkg::*;
#(
    parameter int HOLD = HOLD_ROWS
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     row_start,
    input  logic     short_array,
    input  row_req_t req,
    input  logic     clr_hit,
    output logic     viol
);
    localparam int CNT_W = $clog2(HOLD + 1);

    logic [CNT_W-1:0] hold_cnt;
    logic             hold_busy;
    logic             conflict;
    logic             hold_break;

    assign hold_busy  = (hold_cnt != '0);
    assign conflict   = (req.op == OP_CLR) && req.wr_act && (req.wr_blk != req.addr);
    assign hold_break = hold_busy && (req.op != OP_NOP);
    assign viol       = conflict || hold_break;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
        end else if (row_start) begin
            if (short_array && req.op == OP_CLR && clr_hit && !viol)
                hold_cnt <= CNT_W'(HOLD);
            else if (hold_busy)
                hold_cnt <= hold_cnt - 1'b1;
        end
    end

    AST_HOLD_DRAINS: assert property (@(posedge clk) disable iff (rst)
        (row_start && hold_busy) |=> (hold_cnt == $past(hold_cnt) - 1'b1)); // R9

endmodule

// File: rtl/mirror_blkop_decoder.sv
module mirror_blkop_decoder
    import mbo_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        row_start,
    input  logic [1:0]  op_mode,
    input  logic [3:0]  blk_addr,
    input  logic        grp_sel,
    input  logic        short_array,
    input  logic        wr_active,
    input  logic [3:0]  wr_blk,
    output logic [15:0] clear_mask,
    output logic [15:0] reset_mask,
    output logic [15:0] park_mask,
    output logic        viol_pulse,
    output logic        err_flag
);
    row_req_t   req;
    blk_masks_t dec;
    blk_masks_t out_q;
    logic       grp_now;
    logic       viol_c;

    always_comb begin
        req.op     = op_e'(op_mode);
        req.addr   = blk_addr;
        req.wr_act = wr_active;
        req.wr_blk = wr_blk;
    end

    mbo_grp_stage u_grp (
        .clk       (clk),
        .rst       (rst),
        .row_start (row_start),
        .grp_in    (grp_sel),
        .grp_now   (grp_now)
    );

    mbo_op_decode #(.BLOCKS(NUM_BLK)) u_dec (
        .req         (req),
        .quad        (grp_now),
        .short_array (short_array),
        .masks       (dec)
    );

    mbo_rule_check #(.HOLD(HOLD_ROWS)) u_rule (
        .clk         (clk),
        .rst         (rst),
        .row_start   (row_start),
        .short_array (short_array),
        .req         (req),
        .clr_hit     (|dec.clr),
        .viol        (viol_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q      <= '0;
            viol_pulse <= 1'b0;
            err_flag   <= 1'b0;
        end else begin
            out_q      <= (row_start && !viol_c) ? dec : '0;
            viol_pulse <= row_start && viol_c;
            if (row_start && viol_c)
                err_flag <= 1'b1;
        end
    end

    assign clear_mask = out_q.clr;
    assign reset_mask = out_q.rst;
    assign park_mask  = out_q.park;

    AST_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
        !row_start |=> (clear_mask == '0 && reset_mask == '0 && park_mask == '0 && !viol_pulse)); // R1

    AST_CLR_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clear_mask)); // R3

    AST_KIND_EXCL: assert property (@(posedge clk) disable iff (rst)
        $countones({|clear_mask, |reset_mask, |park_mask}) <= 1); // R7

    AST_NO_BLK15: assert property (@(posedge clk) disable iff (rst)
        $past(short_array) |-> !(clear_mask[15] || reset_mask[15] || park_mask[15])); // R8

    AST_GROUP_SIZE: assert property (@(posedge clk) disable iff (rst)
        (row_start && op_mode == 2'b11 && !blk_addr[3] && !short_array)
        |=> (viol_pulse || $countones(reset_mask) == 2 || $countones(reset_mask) == 4)); // R5

    AST_CLR_CONFLICT: assert property (@(posedge clk) disable iff (rst)
        (row_start && op_mode == 2'b01 && wr_active && wr_blk != blk_addr)
        |=> (viol_pulse && clear_mask == '0)); // R10

    AST_VIOL_QUIET: assert property (@(posedge clk) disable iff (rst)
        viol_pulse |-> (clear_mask == '0 && reset_mask == '0 && park_mask == '0 && err_flag)); // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        err_flag |=> err_flag); // R11

endmodule

// File: tb/mirror_blkop_decoder_bench.sv
module mirror_blkop_decoder_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        row_start = 1'b0;
    logic [1:0]  op_mode = 2'b00;
    logic [3:0]  blk_addr = 4'h0;
    logic        grp_sel = 1'b0;
    logic        short_array = 1'b0;
    logic        wr_active = 1'b0;
    logic [3:0]  wr_blk = 4'h0;
    logic [15:0] clear_mask, reset_mask, park_mask;
    logic        viol_pulse, err_flag;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    mirror_blkop_decoder u_mirror_blkop_decoder (
        .clk         (clk),
        .rst         (rst),
        .row_start   (row_start),
        .op_mode     (op_mode),
        .blk_addr    (blk_addr),
        .grp_sel     (grp_sel),
        .short_array (short_array),
        .wr_active   (wr_active),
        .wr_blk      (wr_blk),
        .clear_mask  (clear_mask),
        .reset_mask  (reset_mask),
        .park_mask   (park_mask),
        .viol_pulse  (viol_pulse),
        .err_flag    (err_flag)
    );

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        row_start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "clear after reset", clear_mask, 16'h0);
        chk("R1", "reset after reset", reset_mask, 16'h0);
        chk("R1", "park after reset", park_mask, 16'h0);
        chk("R1", "err after reset", {15'h0, err_flag}, 16'h0);
    endtask

    // One row cycle: drive the request, check the pulse, then check it is gone.
    task automatic row(input string tag, input logic [1:0] m, input logic [3:0] a, input logic g,
                       input logic wa, input logic [3:0] wb,
                       input logic [15:0] ec, input logic [15:0] er, input logic [15:0] ep,
                       input logic ev);
        @(negedge clk);
        op_mode = m; blk_addr = a; grp_sel = g; wr_active = wa; wr_blk = wb;
        row_start = 1'b1;
        @(negedge clk);
        row_start = 1'b0;
        op_mode = 2'b00; wr_active = 1'b0;
        chk(tag, "clear_mask", clear_mask, ec);
        chk(tag, "reset_mask", reset_mask, er);
        chk(tag, "park_mask", park_mask, ep);
        chk(tag, "viol_pulse", {15'h0, viol_pulse}, {15'h0, ev});
        @(negedge clk);
        chk("R1", "masks after pulse", clear_mask | reset_mask | park_mask, 16'h0);
        chk("R1", "viol after pulse", {15'h0, viol_pulse}, 16'h0);
    endtask

    task automatic t_noop();
        row("R2", 2'b00, 4'h5, 1'b0, 1'b0, 4'h0, 16'h0, 16'h0, 16'h0, 1'b0);
        row("R2", 2'b00, 4'hF, 1'b0, 1'b0, 4'h0, 16'h0, 16'h0, 16'h0, 1'b0);
    endtask

    task automatic t_single();
        row("R3", 2'b01, 4'h3, 1'b1, 1'b0, 4'h0, 16'h0008, 16'h0, 16'h0, 1'b0);
        row("R3", 2'b01, 4'hF, 1'b0, 1'b0, 4'h0, 16'h8000, 16'h0, 16'h0, 1'b0);
        row("R4", 2'b10, 4'h9, 1'b0, 1'b0, 4'h0, 16'h0, 16'h0200, 16'h0, 1'b0);
    endtask

    task automatic t_pair();
        row("R5", 2'b11, 4'b0101, 1'b0, 1'b0, 4'h0, 16'h0, 16'h0C00, 16'h0, 1'b0);
        row("R5", 2'b11, 4'b0000, 1'b0, 1'b0, 4'h0, 16'h0, 16'h0003, 16'h0, 1'b0);
    endtask

    task automatic t_quad_lag();
        row("R12", 2'b11, 4'b0011, 1'b1, 1'b0, 4'h0, 16'h0, 16'h00C0, 16'h0, 1'b0);
        row("R6",  2'b11, 4'b0011, 1'b1, 1'b0, 4'h0, 16'h0, 16'h00F0, 16'h0, 1'b0);
        row("R6",  2'b11, 4'b0110, 1'b1, 1'b0, 4'h0, 16'h0, 16'hF000, 16'h0, 1'b0);
        row("R12", 2'b11, 4'b0110, 1'b0, 1'b0, 4'h0, 16'h0, 16'hF000, 16'h0, 1'b0);
        row("R12", 2'b11, 4'b0110, 1'b0, 1'b0, 4'h0, 16'h0, 16'h3000, 16'h0, 1'b0);
    endtask

    task automatic t_global_park();
        row("R7", 2'b11, 4'b1011, 1'b1, 1'b0, 4'h0, 16'h0, 16'hFFFF, 16'h0, 1'b0);
        row("R7", 2'b11, 4'b1100, 1'b1, 1'b0, 4'h0, 16'h0, 16'h0, 16'hFFFF, 1'b0);
    endtask

    task automatic t_short15();
        short_array = 1'b1;
        row("R8", 2'b11, 4'b0110, 1'b1, 1'b0, 4'h0, 16'h0, 16'h7000, 16'h0, 1'b0);
        row("R8", 2'b11, 4'b1000, 1'b1, 1'b0, 4'h0, 16'h0, 16'h7FFF, 16'h0, 1'b0);
        row("R8", 2'b11, 4'b1111, 1'b1, 1'b0, 4'h0, 16'h0, 16'h0, 16'h7FFF, 1'b0);
        row("R8", 2'b01, 4'hF, 1'b1, 1'b0, 4'h0, 16'h0, 16'h0, 16'h0, 1'b0);
        row("R8", 2'b10, 4'hF, 1'b1, 1'b0, 4'h0, 16'h0, 16'h0, 16'h0, 1'b0);
        row("R8", 2'b10, 4'hE, 1'b1, 1'b0, 4'h0, 16'h0, 16'h4000, 16'h0, 1'b0);
        short_array = 1'b0;
    endtask

    task automatic t_conflict();
        do_reset();
        row("R10", 2'b01, 4'h4, 1'b0, 1'b1, 4'h7, 16'h0, 16'h0, 16'h0, 1'b1);
        chk("R11", "err after conflict", {15'h0, err_flag}, 16'h1);
        row("R10", 2'b01, 4'h4, 1'b0, 1'b1, 4'h4, 16'h0010, 16'h0, 16'h0, 1'b0);
        row("R10", 2'b10, 4'h3, 1'b0, 1'b1, 4'h9, 16'h0, 16'h0008, 16'h0, 1'b0);
        row("R10", 2'b01, 4'h6, 1'b0, 1'b0, 4'h2, 16'h0040, 16'h0, 16'h0, 1'b0);
    endtask

    task automatic t_holdoff();
        do_reset();
        short_array = 1'b1;
        row("R9", 2'b01, 4'h2, 1'b0, 1'b0, 4'h0, 16'h0004, 16'h0, 16'h0, 1'b0);
        row("R9", 2'b00, 4'h0, 1'b0, 1'b0, 4'h0, 16'h0, 16'h0, 16'h0, 1'b0);
        row("R9", 2'b10, 4'h5, 1'b0, 1'b0, 4'h0, 16'h0, 16'h0, 16'h0, 1'b1);
        chk("R11", "err after holdoff break", {15'h0, err_flag}, 16'h1);
        row("R9", 2'b10, 4'h5, 1'b0, 1'b0, 4'h0, 16'h0, 16'h0020, 16'h0, 1'b0);
        row("R9", 2'b01, 4'h7, 1'b0, 1'b0, 4'h0, 16'h0080, 16'h0, 16'h0, 1'b0);
        row("R9", 2'b11, 4'b1000, 1'b0, 1'b0, 4'h0, 16'h0, 16'h0, 16'h0, 1'b1);
        row("R9", 2'b00, 4'h0, 1'b0, 1'b0, 4'h0, 16'h0, 16'h0, 16'h0, 1'b0);
        row("R9", 2'b11, 4'b1000, 1'b0, 1'b0, 4'h0, 16'h0, 16'h7FFF, 16'h0, 1'b0);
        chk("R11", "err stays set", {15'h0, err_flag}, 16'h1);
        short_array = 1'b0;
        row("R9", 2'b01, 4'h2, 1'b0, 1'b0, 4'h0, 16'h0004, 16'h0, 16'h0, 1'b0);
        row("R9", 2'b10, 4'h3, 1'b0, 1'b0, 4'h0, 16'h0, 16'h0008, 16'h0, 1'b0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #1_000_000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got hung expected done");
        summary();
    end

    initial begin
        do_reset();
        t_noop();
        t_single();
        t_pair();
        t_quad_lag();
        t_global_park();
        t_short15();
        t_conflict();
        t_holdoff();
        summary();
    end

endmodule